// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor that runs one instruction at a time through a fetch, decode and execute sequence. It holds a program counter, a memory address register, a memory data register, an instruction register, an accumulator and one auxiliary X register. It reaches a single-port, word-addressed memory with one cycle of read latency. Every access, read or write, is made through the address and data registers. The memory address is always the address register, and the write data is always the data register.

Five operations are recognised: load the accumulator from memory, load X through a pointer held in memory, subtract X from the accumulator, branch when the accumulator is zero or negative, and store the accumulator. Any other opcode parks the core in a halted state. After each instruction the core gives a one-cycle completion pulse. The register outputs are final in that same cycle, so an outside model can compare them after each instruction.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous reset clears the accumulator, X, address, data and instruction registers. It loads the program counter from `rst_vec`, holds `halted`, `instr_done` and `mem_we` low, and leaves the halted state.
- R2: An instruction word carries the opcode in its upper 8 bits and an operand address in its lower ADDR_W bits. Fetch places the program counter on `mem_addr` one cycle after the instruction starts. Fetch plus decode take 5 cycles.
- R3: Decode adds exactly 1 to the program counter for every opcode, including undefined ones.
- R4: Opcode 0x10 loads the accumulator with the word at the operand address. It takes 9 cycles.
- R5: Opcode 0x30 reads the word at the operand address and uses its low ADDR_W bits as a pointer. It then loads X with the word at that pointer and leaves the accumulator unchanged. It takes 12 cycles.
- R6: Opcode 0x20 replaces the accumulator with accumulator minus X, modulo 2^DATA_W in two's complement. It takes 6 cycles.
- R7: Opcode 0x90 loads the program counter with the operand when the accumulator, read as signed, is zero or negative. Otherwise the incremented value stays. It takes 6 cycles.
- R8: Opcode 0x50 writes the accumulator to the operand address with `mem_we` high for exactly one cycle. It takes 7 cycles. `mem_we` is never high outside this instruction.
- R9: Any other opcode raises `halted`, which then stays high until reset. After that no write, no completion pulse and no change to the program counter, accumulator or X occurs.
- R10: `instr_done` is high for exactly one cycle after each completed instruction, and the register outputs already hold that instruction's results in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rst_vec | input | ADDR_W | Program counter value loaded on reset |
| mem_addr | output | ADDR_W | Memory word address (address register) |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| mem_wdata | output | DATA_W | Memory write data (data register) |
| mem_we | output | 1 | Memory write enable |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |
| x_o | output | DATA_W | X register |
| state_o | output | 5 | Sequencer state code |
| instr_done | output | 1 | One-cycle pulse after each completed instruction |
| halted | output | 1 | High while parked on an undefined opcode |

## Verification
The hardest case to reach is the indirect X load. Its result depends on two chained reads, and only the low bits of the first word may act as the pointer. The stimulus stores a pointer word with non-zero upper bits, so that a core using the whole word would fetch the wrong cell. The sign test of the branch is also reached only through arithmetic: the bench builds a zero, a negative and a wrapped positive accumulator through subtraction before each branch. A halt is then reached by placing an undefined word straight after a store, which shows that no write follows it.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

   localparam int OPC_W   = 8;
   localparam int STATE_W = 5;

   localparam logic [OPC_W-1:0] OP_LOAD_A     = 8'h10;
   localparam logic [OPC_W-1:0] OP_SUB_X      = 8'h20;
   localparam logic [OPC_W-1:0] OP_LOAD_X_IND = 8'h30;
   localparam logic [OPC_W-1:0] OP_STORE_A    = 8'h50;
   localparam logic [OPC_W-1:0] OP_JUMP_LEZ   = 8'h90;

   typedef enum logic [STATE_W-1:0] {
      S_FADR  = 5'd0,
      S_FWAIT = 5'd1,
      S_FRD   = 5'd2,
      S_FIR   = 5'd3,
      S_DEC   = 5'd4,
      S_OADR  = 5'd5,
      S_OWAIT = 5'd6,
      S_ORD   = 5'd7,
      S_PADR  = 5'd8,
      S_PWAIT = 5'd9,
      S_PRD   = 5'd10,
      S_WBA   = 5'd11,
      S_WBX   = 5'd12,
      S_SUB   = 5'd13,
      S_JMP   = 5'd14,
      S_SADR  = 5'd15,
      S_SWR   = 5'd16,
      S_HALT  = 5'd17
   } state_e;

   typedef struct packed {
      logic mar_pc;
      logic mar_opnd;
      logic mar_ptr;
      logic mdr_mem;
      logic mdr_acc;
      logic ir_ld;
      logic pc_inc;
      logic pc_jmp;
      logic acc_mdr;
      logic acc_alu;
      logic x_mdr;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu #(
   parameter int DATA_W    = 16,
   parameter int SUB_STYLE = 0
) (
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] xval,
   output logic [DATA_W-1:0] diff,
   output logic              lez
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (SUB_STYLE == 0) begin : g_sub_direct
         assign diff = acc - xval;
      end else if (SUB_STYLE == 1) begin : g_sub_invadd
         assign diff = acc + ~xval + ONE;
      end else begin : g_sub_bad
         $error("acc_cpu_alu: SUB_STYLE must be 0 or 1");
      end
   endgenerate

   assign lez = acc[DATA_W-1] | (acc == '0);

endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   input  logic             lez,
   output ctl_t             ctl,
   output logic             mem_we,
   output state_e           state,
   output logic             done,
   output logic             halted
);

   state_e state_q, state_d;
   logic   fin;
   logic   done_q;

   always_comb begin
      state_d = state_q;
      ctl     = '0;
      mem_we  = 1'b0;
      fin     = 1'b0;
      case (state_q)
         S_FADR: begin
            ctl.mar_pc = 1'b1;
            state_d    = S_FWAIT;
         end
         S_FWAIT: state_d = S_FRD;
         S_FRD: begin
            ctl.mdr_mem = 1'b1;
            state_d     = S_FIR;
         end
         S_FIR: begin
            ctl.ir_ld = 1'b1;
            state_d   = S_DEC;
         end
         S_DEC: begin
            ctl.pc_inc = 1'b1;
            case (opcode)
               OP_LOAD_A, OP_LOAD_X_IND: state_d = S_OADR;
               OP_SUB_X:                 state_d = S_SUB;
               OP_JUMP_LEZ:              state_d = S_JMP;
               OP_STORE_A:               state_d = S_SADR;
               default:                  state_d = S_HALT;
            endcase
         end
         S_OADR: begin
            ctl.mar_opnd = 1'b1;
            state_d      = S_OWAIT;
         end
         S_OWAIT: state_d = S_ORD;
         S_ORD: begin
            ctl.mdr_mem = 1'b1;
            state_d     = (opcode == OP_LOAD_X_IND) ? S_PADR : S_WBA;
         end
         S_PADR: begin
            ctl.mar_ptr = 1'b1;
            state_d     = S_PWAIT;
         end
         S_PWAIT: state_d = S_PRD;
         S_PRD: begin
            ctl.mdr_mem = 1'b1;
            state_d     = S_WBX;
         end
         S_WBA: begin
            ctl.acc_mdr = 1'b1;
            fin         = 1'b1;
            state_d     = S_FADR;
         end
         S_WBX: begin
            ctl.x_mdr = 1'b1;
            fin       = 1'b1;
            state_d   = S_FADR;
         end
         S_SUB: begin
            ctl.acc_alu = 1'b1;
            fin         = 1'b1;
            state_d     = S_FADR;
         end
         S_JMP: begin
            ctl.pc_jmp = lez;
            fin        = 1'b1;
            state_d    = S_FADR;
         end
         S_SADR: begin
            ctl.mar_opnd = 1'b1;
            ctl.mdr_acc  = 1'b1;
            state_d      = S_SWR;
         end
         S_SWR: begin
            mem_we  = 1'b1;
            fin     = 1'b1;
            state_d = S_FADR;
         end
         S_HALT:  state_d = S_HALT;
         default: state_d = S_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= S_FADR;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= fin;
      end
   end

   assign state  = state_q;
   assign done   = done_q;
   assign halted = (state_q == S_HALT);

endmodule

// File: rtl/acc_cpu_dpath.sv
`timescale 1ns/1ps
module acc_cpu_dpath
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rst_vec,
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] diff,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mdr,
   output logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] xreg
);

   localparam logic [ADDR_W-1:0] PC_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] ir;
   logic [ADDR_W-1:0] operand;

   assign operand = ir[ADDR_W-1:0];
   assign opcode  = ir[DATA_W-1 -: OPC_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         pc   <= rst_vec;
         mar  <= '0;
         mdr  <= '0;
         ir   <= '0;
         acc  <= '0;
         xreg <= '0;
      end else begin
         if (ctl.mar_pc)        mar <= pc;
         else if (ctl.mar_opnd) mar <= operand;
         else if (ctl.mar_ptr)  mar <= mdr[ADDR_W-1:0];

         if (ctl.mdr_mem)      mdr <= mem_rdata;
         else if (ctl.mdr_acc) mdr <= acc;

         if (ctl.ir_ld) ir <= mdr;

         if (ctl.pc_inc)      pc <= pc + PC_STEP;
         else if (ctl.pc_jmp) pc <= operand;

         if (ctl.acc_mdr)      acc <= mdr;
         else if (ctl.acc_alu) acc <= diff;

         if (ctl.x_mdr) xreg <= mdr;
      end
   end

endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 8,
   parameter int SUB_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rst_vec,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] x_o,
   output logic [4:0]        state_o,
   output logic              instr_done,
   output logic              halted
);

   generate
      if (DATA_W != ADDR_W + OPC_W) begin : g_bad_width
         $error("acc_cpu_core: DATA_W must equal ADDR_W plus the opcode width");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("acc_cpu_core: ADDR_W must be at least 2");
      end
   endgenerate

   ctl_t              ctl;
   state_e            state;
   logic [OPC_W-1:0]  opcode;
   logic              lez;
   logic [DATA_W-1:0] diff;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] xreg;

   acc_cpu_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (opcode),
      .lez    (lez),
      .ctl    (ctl),
      .mem_we (mem_we),
      .state  (state),
      .done   (instr_done),
      .halted (halted)
   );

   acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
      .clk       (clk),
      .rst       (rst),
      .rst_vec   (rst_vec),
      .ctl       (ctl),
      .mem_rdata (mem_rdata),
      .diff      (diff),
      .mar       (mem_addr),
      .mdr       (mem_wdata),
      .opcode    (opcode),
      .pc        (pc_o),
      .acc       (acc),
      .xreg      (xreg)
   );

   acc_cpu_alu #(.DATA_W(DATA_W), .SUB_STYLE(SUB_STYLE)) u_alu (
      .acc  (acc),
      .xval (xreg),
      .diff (diff),
      .lez  (lez)
   );

   assign acc_o   = acc;
   assign x_o     = xreg;
   assign state_o = state;

endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [4:0]        state,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] acc,
   input logic [DATA_W-1:0] xval,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_we,
   input logic              done,
   input logic              halted
);

   // R2
   fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_FWAIT) |-> (mem_addr == pc));

   // R3
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_DEC) |=> (pc == ADDR_W'($past(pc) + 1)));

   // R5
   ldx_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_WBX) |=> $stable(acc));

   // R8
   store_data_chk: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_wdata == acc));

   // R8
   store_single_chk: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   // R9
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(pc) && $stable(acc) && $stable(xval)));

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!mem_we && !done));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R10
   done_at_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (state == S_FADR));

endmodule

bind acc_cpu_core acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .state     (state_o),
   .pc        (pc_o),
   .acc       (acc_o),
   .xval      (x_o),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_we    (mem_we),
   .done      (instr_done),
   .halted    (halted)
);

// File: tb/sim_acc_cpu_core.sv
`timescale 1ns/1ps
module sim_acc_cpu_core;

   localparam int DW = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] rst_vec = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [AW-1:0] pc_o;
   logic [DW-1:0] acc_o;
   logic [DW-1:0] x_o;
   logic [4:0]    state_o;
   logic          instr_done;
   logic          halted;

   logic [DW-1:0] mem [256];
   int n_chk = 0;
   int n_err = 0;
   int we_cnt = 0;

   always #10 clk = ~clk;   // 50 MHz

   acc_cpu_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk        (clk),
      .rst        (rst),
      .rst_vec    (rst_vec),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .mem_wdata  (mem_wdata),
      .mem_we     (mem_we),
      .pc_o       (pc_o),
      .acc_o      (acc_o),
      .x_o        (x_o),
      .state_o    (state_o),
      .instr_done (instr_done),
      .halted     (halted)
   );

   // memory model: registered read, one cycle latency
   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         we_cnt        <= we_cnt + 1;
      end
      mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = '0;
   endtask

   task automatic do_reset(input logic [AW-1:0] vec);
      @(negedge clk);
      rst     = 1'b1;
      rst_vec = vec;
      repeat (2) @(negedge clk);
   endtask

   task automatic release_reset();
      rst = 1'b0;
   endtask

   // counts rising edges until the completion pulse is seen
   task automatic step(output int cyc);
      cyc = 0;
      do begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end while (!instr_done && cyc < 100);
      if (!instr_done) chk("R10", "completion pulse timeout", 0, 1);
   endtask

   task automatic check_halt(input string tag, input logic [AW-1:0] exp_pc,
                             input logic [DW-1:0] exp_acc, input logic [DW-1:0] exp_x);
      int dones = 0;
      int w0    = we_cnt;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (instr_done) dones++;
      end
      chk("R9", {tag, " halted"}, halted, 1);
      chk("R9", {tag, " no pulse"}, dones, 0);
      chk("R9", {tag, " no write"}, we_cnt - w0, 0);
      chk("R3", {tag, " pc after undefined decode"}, pc_o, exp_pc);
      chk("R9", {tag, " acc frozen"}, acc_o, exp_acc);
      chk("R9", {tag, " x frozen"}, x_o, exp_x);
   endtask

   // negative result, taken branch, store, halt
   task automatic test_walkthrough();
      int cyc;
      int w0;
      clear_mem();
      mem[8'h05] = 16'h1016; mem[8'h06] = 16'h3015; mem[8'h07] = 16'h2000;
      mem[8'h08] = 16'h900A; mem[8'h0A] = 16'h5019; mem[8'h0B] = 16'h0000;
      mem[8'h16] = 16'h000F; mem[8'h15] = 16'h0014; mem[8'h14] = 16'h0012;
      mem[8'h19] = 16'h0000;
      do_reset(8'h05);
      chk("R1", "reset pc", pc_o, 8'h05);
      chk("R1", "reset acc", acc_o, 0);
      chk("R1", "reset x", x_o, 0);
      chk("R1", "reset halted", halted, 0);
      chk("R1", "reset done", instr_done, 0);
      chk("R1", "reset we", mem_we, 0);
      release_reset();
      @(posedge clk); @(negedge clk);
      chk("R2", "fetch address", mem_addr, 8'h05);
      step(cyc);
      chk("R4", "load A cycles", cyc + 1, 9);
      chk("R4", "load A value", acc_o, 16'h000F);
      chk("R3", "pc after load A", pc_o, 8'h06);
      @(posedge clk); @(negedge clk);
      chk("R10", "pulse one cycle", instr_done, 0);
      step(cyc);
      chk("R5", "load X cycles", cyc + 1, 12);
      chk("R5", "indirect X value", x_o, 16'h0012);
      chk("R5", "acc untouched", acc_o, 16'h000F);
      step(cyc);
      chk("R6", "sub cycles", cyc, 6);
      chk("R6", "negative difference", acc_o, 16'hFFFD);
      chk("R3", "pc after sub", pc_o, 8'h08);
      step(cyc);
      chk("R7", "branch cycles", cyc, 6);
      chk("R7", "negative branch taken", pc_o, 8'h0A);
      w0 = we_cnt;
      step(cyc);
      chk("R8", "store cycles", cyc, 7);
      chk("R8", "stored word", mem[8'h19], 16'hFFFD);
      chk("R8", "single write", we_cnt - w0, 1);
      chk("R10", "pc visible at pulse", pc_o, 8'h0B);
      check_halt("walk", 8'h0C, 16'hFFFD, 16'h0012);
   endtask

   // wrapped subtraction, untaken branch, pointer upper bits ignored
   task automatic test_wrap();
      int cyc;
      clear_mem();
      mem[8'h20] = 16'h1070; mem[8'h21] = 16'h3071; mem[8'h22] = 16'h2000;
      mem[8'h23] = 16'h9030; mem[8'h24] = 16'h5073; mem[8'h25] = 16'hFF00;
      mem[8'h70] = 16'h8000; mem[8'h71] = 16'hAB72; mem[8'h72] = 16'h0001;
      mem[8'hAB] = 16'h5555;
      do_reset(8'h20);
      release_reset();
      step(cyc);
      chk("R4", "load A min value", acc_o, 16'h8000);
      step(cyc);
      chk("R5", "pointer low bits only", x_o, 16'h0001);
      step(cyc);
      chk("R6", "wrap to positive", acc_o, 16'h7FFF);
      step(cyc);
      chk("R7", "positive branch not taken", pc_o, 8'h24);
      step(cyc);
      chk("R8", "stored wrapped value", mem[8'h73], 16'h7FFF);
      check_halt("wrap", 8'h26, 16'h7FFF, 16'h0001);
   endtask

   // zero accumulator takes the branch; reset leaves halt
   task automatic test_zero();
      int cyc;
      clear_mem();
      mem[8'h40] = 16'h1080; mem[8'h41] = 16'h9060;
      mem[8'h60] = 16'h2000; mem[8'h61] = 16'h9045;
      mem[8'h45] = 16'h7700; mem[8'h42] = 16'h5099;
      mem[8'h80] = 16'h0000;
      do_reset(8'h40);
      release_reset();
      step(cyc);
      chk("R4", "load zero", acc_o, 0);
      step(cyc);
      chk("R7", "zero branch taken", pc_o, 8'h60);
      step(cyc);
      chk("R6", "zero minus zero", acc_o, 0);
      step(cyc);
      chk("R7", "second zero branch", pc_o, 8'h45);
      check_halt("zero", 8'h46, 16'h0000, 16'h0000);
      do_reset(8'h40);
      chk("R1", "reset clears halt", halted, 0);
      chk("R1", "reset reloads pc", pc_o, 8'h40);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      test_walkthrough();
      test_wrap();
      test_zero();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule